// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block holds every memory operation that is in flight, kept in program order, and works out each cycle which of them may execute under a relaxed ordering model. Dispatch presents one operation per cycle as three attribute flags: reads memory, writes memory, has side effects. The block classifies the operation as a load, a store, or one of three barrier kinds, and places it in a circular slot ring. Loads and stores leave the ring when the execution side reports them complete. Barriers never leave that way: a barrier executes by itself once nothing older is left, and its slot is freed on the following cycle.

The output is a per-slot permission vector, a flag saying whether any slot holds permission, and the slot number of the oldest permitted entry. A permission bit stays set until the entry leaves the ring. Tracking which permitted entries have already been sent is the consumer's task. Loads and stores have separate occupancy limits, set through configuration inputs. A limit of zero selects the built-in default. One mode input decides whether a load may overtake an older store.

Top module: `mem_order_queue`

## Requirements
- R1: After reset the ring is empty: `ready_vec` is all zero and `ready_any` is low. `disp_accept` is low whenever `disp_valid` is low.
- R2: Flags are classified as follows. Side effects with both read and write gives a full barrier. Side effects with read only gives a load barrier. Side effects with write only gives a store barrier. Without side effects, any write gives a store and a read alone gives a load. A request with neither read nor write is refused. An accepted operation gets slot `disp_slot`, and slots are handed out in rising order modulo DEPTH.
- R3: A store is never permitted while any older load or older store is still in the ring. The mode input does not change this.
- R4: A load may be permitted ahead of an older load. It is held back if a store or any barrier lies between that older load and itself.
- R5: A load with an older store in the ring may be permitted while `cfg_strict_alias` is 0. It is held back while `cfg_strict_alias` is 1.
- R6: A barrier is permitted only when no older entry is in the ring. Its permission lasts exactly one cycle, and its slot is free in the cycle after that.
- R7: An older load barrier or full barrier holds back every younger load until the barrier's slot is freed. An older store barrier or full barrier does the same for every younger store. A load with no older load ahead of a store barrier may pass that barrier.
- R8: A load is refused while the number of loads in the ring equals the load limit. A store is refused while the number of stores equals the store limit. A limit input of 0 selects the default parameter value.
- R9: The ring is full when DEPTH slots lie between the oldest unretired slot and the allocation point, freed holes included. Any request is refused while the ring is full, and an accepted request never overwrites a live slot.
- R10: A completion for a live load or store frees that slot in the next cycle. A completion that names a barrier slot is ignored.
- R11: `ready_oldest` names the permitted slot that is oldest in program order, counting from the oldest unretired slot.
- R12: An allocation and a completion in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_reads | input | 1 | Operation reads memory |
| disp_writes | input | 1 | Operation writes memory |
| disp_side_fx | input | 1 | Operation has side effects |
| disp_accept | output | 1 | Request accepted this cycle |
| disp_slot | output | $clog2(DEPTH) | Slot given to an accepted request |
| done_valid | input | 1 | Completion report this cycle |
| done_slot | input | $clog2(DEPTH) | Slot of the completed load or store |
| cfg_lq_cap | input | $clog2(DEPTH+1) | Load limit, 0 selects LQ_DEF |
| cfg_sq_cap | input | $clog2(DEPTH+1) | Store limit, 0 selects SQ_DEF |
| cfg_strict_alias | input | 1 | 1 keeps loads behind older stores |
| ready_vec | output | DEPTH | Per-slot execution permission |
| ready_any | output | 1 | Some slot is permitted |
| ready_oldest | output | $clog2(DEPTH) | Oldest permitted slot |

## Verification
The interesting overlap is an allocation into the tail slot in the same cycle that a completion frees an older slot. The bench provokes this by completing a store while dispatching a new store. It then checks two things in the next cycle: the freed slot's permission bit is gone, and the new store sits blocked behind the remaining older load. A second overlap comes when the ring fills while a completion opens a hole in the middle. The bench checks that the request in that cycle is still refused, and that the oldest-permitted output skips the hole.

// File: rtl/oq_pkg.sv
package oq_pkg;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_LOAD  = 3'd1,
        K_STORE = 3'd2,
        K_LBAR  = 3'd3,
        K_SBAR  = 3'd4,
        K_FBAR  = 3'd5
    } op_kind_e;

    typedef struct packed {
        logic     live;
        logic     fired;
        op_kind_e kind;
    } slot_t;

    function automatic op_kind_e classify(logic rd, logic wr, logic fx);
        if (fx && rd && wr) return K_FBAR;
        if (fx && rd)       return K_LBAR;
        if (fx && wr)       return K_SBAR;
        if (wr)             return K_STORE;
        if (rd)             return K_LOAD;
        return K_NONE;
    endfunction

    function automatic logic is_barrier(op_kind_e k);
        return (k == K_LBAR) || (k == K_SBAR) || (k == K_FBAR);
    endfunction

    function automatic logic fences_loads(op_kind_e k);
        return (k == K_LBAR) || (k == K_FBAR);
    endfunction

    function automatic logic fences_stores(op_kind_e k);
        return (k == K_SBAR) || (k == K_FBAR);
    endfunction

    function automatic logic splits_loads(op_kind_e k);
        return (k == K_STORE) || is_barrier(k);
    endfunction

endpackage

// File: rtl/oq_alloc_ctrl.sv
module oq_alloc_ctrl
    import oq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int LQ_DEF = 4,
    parameter int SQ_DEF = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  op_kind_e                     req_kind,
    input  logic                         head_free,
    input  logic [$clog2(DEPTH+1)-1:0]   lq_used,
    input  logic [$clog2(DEPTH+1)-1:0]   sq_used,
    input  logic [$clog2(DEPTH+1)-1:0]   cfg_lq_cap,
    input  logic [$clog2(DEPTH+1)-1:0]   cfg_sq_cap,
    output logic                         grant,
    output logic [$clog2(DEPTH)-1:0]     head_idx,
    output logic [$clog2(DEPTH)-1:0]     tail_idx
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] head_q, tail_q, occ;
    logic [CW-1:0] lq_lim, sq_lim;
    logic          ring_full, room_ok;

    assign occ       = tail_q - head_q;
    assign ring_full = (occ == PW'(DEPTH));
    assign lq_lim    = (cfg_lq_cap == '0) ? CW'(LQ_DEF) : cfg_lq_cap;
    assign sq_lim    = (cfg_sq_cap == '0) ? CW'(SQ_DEF) : cfg_sq_cap;

    always_comb begin
        unique case (req_kind)
            K_NONE:  room_ok = 1'b0;
            K_LOAD:  room_ok = (lq_used < lq_lim);
            K_STORE: room_ok = (sq_used < sq_lim);
            default: room_ok = 1'b1;
        endcase
    end

    assign grant    = req_valid && !ring_full && room_ok;
    assign head_idx = head_q[IW-1:0];
    assign tail_idx = tail_q[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (grant)
                tail_q <= tail_q + PW'(1);
            if ((occ != '0) && head_free)
                head_q <= head_q + PW'(1);
        end
    end

    // R9
    occ_range_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= PW'(DEPTH))
        else $error("ring occupancy beyond depth");

endmodule

// File: rtl/oq_order_rules.sv
module oq_order_rules
    import oq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  slot_t                    slots [DEPTH],
    input  logic [$clog2(DEPTH)-1:0] head_idx,
    input  logic                     strict_alias,
    output logic [DEPTH-1:0]         may_go
);
    localparam int IW = $clog2(DEPTH);

    logic [IW-1:0]    rel [DEPTH];
    logic [DEPTH-1:0] split_after_load;

    for (genvar g = 0; g < DEPTH; g++) begin : g_rel
        assign rel[g] = IW'(g) - head_idx;
    end

    // a store or barrier that has a load older than itself
    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            split_after_load[j] = 1'b0;
            if (slots[j].live && splits_loads(slots[j].kind)) begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (slots[k].live && (slots[k].kind == K_LOAD) && (rel[k] < rel[j]))
                        split_after_load[j] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic any_old, old_ld, old_st, old_lf, old_sf, old_split;
            any_old   = 1'b0;
            old_ld    = 1'b0;
            old_st    = 1'b0;
            old_lf    = 1'b0;
            old_sf    = 1'b0;
            old_split = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (slots[j].live && (rel[j] < rel[i])) begin
                    any_old = 1'b1;
                    if (slots[j].kind == K_LOAD)  old_ld = 1'b1;
                    if (slots[j].kind == K_STORE) old_st = 1'b1;
                    if (fences_loads(slots[j].kind))  old_lf = 1'b1;
                    if (fences_stores(slots[j].kind)) old_sf = 1'b1;
                    if (split_after_load[j]) old_split = 1'b1;
                end
            end
            may_go[i] = 1'b0;
            if (slots[i].live && !slots[i].fired) begin
                unique case (slots[i].kind)
                    K_LOAD:  may_go[i] = !old_lf && !old_split && !(strict_alias && old_st);
                    K_STORE: may_go[i] = !old_ld && !old_st && !old_sf;
                    K_LBAR, K_SBAR, K_FBAR: may_go[i] = !any_old;
                    default: may_go[i] = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/oq_age_pick.sv
module oq_age_pick #(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DEPTH-1:0]         req,
    input  logic [$clog2(DEPTH)-1:0] head_idx,
    output logic                     found,
    output logic [$clog2(DEPTH)-1:0] pick_idx
);
    localparam int IW = $clog2(DEPTH);

    logic [IW-1:0] cand [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cand
        assign cand[g] = head_idx + IW'(g);
    end

    always_comb begin
        found    = 1'b0;
        pick_idx = head_idx;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (req[cand[k]]) begin
                found    = 1'b1;
                pick_idx = cand[k];
            end
        end
    end

    // R11
    pick_hit_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> req[pick_idx])
        else $error("picked slot holds no permission");

endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
    import oq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int LQ_DEF = 4,
    parameter int SQ_DEF = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         disp_valid,
    input  logic                         disp_reads,
    input  logic                         disp_writes,
    input  logic                         disp_side_fx,
    output logic                         disp_accept,
    output logic [$clog2(DEPTH)-1:0]     disp_slot,
    input  logic                         done_valid,
    input  logic [$clog2(DEPTH)-1:0]     done_slot,
    input  logic [$clog2(DEPTH+1)-1:0]   cfg_lq_cap,
    input  logic [$clog2(DEPTH+1)-1:0]   cfg_sq_cap,
    input  logic                         cfg_strict_alias,
    output logic [DEPTH-1:0]             ready_vec,
    output logic                         ready_any,
    output logic [$clog2(DEPTH)-1:0]     ready_oldest
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    slot_t         slots_q [DEPTH];
    op_kind_e      req_kind;
    logic [CW-1:0] lq_used, sq_used;
    logic [IW-1:0] head_idx, tail_idx;
    logic          head_free;

    assign req_kind  = classify(disp_reads, disp_writes, disp_side_fx);
    assign head_free = !slots_q[head_idx].live;
    assign disp_slot = tail_idx;

    always_comb begin
        lq_used = '0;
        sq_used = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slots_q[i].live && (slots_q[i].kind == K_LOAD))  lq_used = lq_used + CW'(1);
            if (slots_q[i].live && (slots_q[i].kind == K_STORE)) sq_used = sq_used + CW'(1);
        end
    end

    oq_alloc_ctrl #(.DEPTH(DEPTH), .LQ_DEF(LQ_DEF), .SQ_DEF(SQ_DEF)) u_alloc (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (disp_valid),
        .req_kind   (req_kind),
        .head_free  (head_free),
        .lq_used    (lq_used),
        .sq_used    (sq_used),
        .cfg_lq_cap (cfg_lq_cap),
        .cfg_sq_cap (cfg_sq_cap),
        .grant      (disp_accept),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx)
    );

    oq_order_rules #(.DEPTH(DEPTH)) u_rules (
        .slots        (slots_q),
        .head_idx     (head_idx),
        .strict_alias (cfg_strict_alias),
        .may_go       (ready_vec)
    );

    oq_age_pick #(.DEPTH(DEPTH)) u_pick (
        .clk      (clk),
        .rst      (rst),
        .req      (ready_vec),
        .head_idx (head_idx),
        .found    (ready_any),
        .pick_idx (ready_oldest)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                slots_q[i] <= '{live: 1'b0, fired: 1'b0, kind: K_NONE};
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (slots_q[i].live && slots_q[i].fired) begin
                    slots_q[i].live  <= 1'b0;
                    slots_q[i].fired <= 1'b0;
                end else if (ready_vec[i] && is_barrier(slots_q[i].kind)) begin
                    slots_q[i].fired <= 1'b1;
                end
                if (done_valid && (done_slot == IW'(i)) && slots_q[i].live &&
                    ((slots_q[i].kind == K_LOAD) || (slots_q[i].kind == K_STORE)))
                    slots_q[i].live <= 1'b0;
                if (disp_accept && (tail_idx == IW'(i)))
                    slots_q[i] <= '{live: 1'b1, fired: 1'b0, kind: req_kind};
            end
        end
    end

    // R9
    no_clobber_chk: assert property (@(posedge clk) disable iff (rst)
        disp_accept |-> !slots_q[disp_slot].live)
        else $error("allocation onto a live slot");

    // R10
    done_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (done_valid && slots_q[done_slot].live &&
         ((slots_q[done_slot].kind == K_LOAD) || (slots_q[done_slot].kind == K_STORE)))
        |=> !slots_q[$past(done_slot)].live)
        else $error("completed entry still live");

    for (genvar g = 0; g < DEPTH; g++) begin : g_bar_chk
        // R6
        barrier_once_chk: assert property (@(posedge clk) disable iff (rst)
            (ready_vec[g] && is_barrier(slots_q[g].kind)) |=> !ready_vec[g])
            else $error("barrier permitted twice");
    end

endmodule

// File: tb/mem_order_queue_tb.sv
module mem_order_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst;
    logic disp_valid, disp_reads, disp_writes, disp_side_fx;
    logic disp_accept;
    logic [IW-1:0] disp_slot;
    logic done_valid;
    logic [IW-1:0] done_slot;
    logic [CW-1:0] cfg_lq_cap, cfg_sq_cap;
    logic cfg_strict_alias;
    logic [DEPTH-1:0] ready_vec;
    logic ready_any;
    logic [IW-1:0] ready_oldest;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_order_queue #(.DEPTH(DEPTH), .LQ_DEF(4), .SQ_DEF(4)) u_dut (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_reads(disp_reads), .disp_writes(disp_writes),
        .disp_side_fx(disp_side_fx), .disp_accept(disp_accept), .disp_slot(disp_slot),
        .done_valid(done_valid), .done_slot(done_slot),
        .cfg_lq_cap(cfg_lq_cap), .cfg_sq_cap(cfg_sq_cap), .cfg_strict_alias(cfg_strict_alias),
        .ready_vec(ready_vec), .ready_any(ready_any), .ready_oldest(ready_oldest)
    );

    typedef enum int {F_ACC, F_SLOT, F_VEC, F_ANY, F_OLD} fld_e;
    typedef struct {
        fld_e        fld;
        int unsigned exp;
        string       tag;
    } exp_t;

    exp_t sb [$];
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // monitor: compares every expectation queued for this cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            int unsigned act;
            e = sb.pop_front();
            case (e.fld)
                F_ACC:   act = 32'(disp_accept);
                F_SLOT:  act = 32'(disp_slot);
                F_VEC:   act = 32'(ready_vec);
                F_ANY:   act = 32'(ready_any);
                default: act = 32'(ready_oldest);
            endcase
            checks++;
            if (act !== e.exp) begin
                errors++;
                $display("FAIL %s field=%0d actual=%0h expected=%0h", e.tag, e.fld, act, e.exp);
            end
        end
    end

    task automatic want(input fld_e f, input int unsigned x, input string t);
        exp_t e;
        e.fld = f; e.exp = x; e.tag = t;
        sb.push_back(e);
    endtask

    task automatic want_vec(input int unsigned v, input int unsigned old, input string t);
        want(F_VEC, v, t);
        want(F_ANY, (v != 0) ? 1 : 0, t);
        if (v != 0) want(F_OLD, old, t);
    endtask

    task automatic want_acc(input int unsigned a, input int unsigned s, input string t);
        want(F_ACC, a, t);
        if (a != 0) want(F_SLOT, s, t);
    endtask

    task automatic cyc(input bit v, input bit rd, input bit wr, input bit fx,
                       input bit dv, input int ds);
        @(posedge clk); #1;
        disp_valid = v; disp_reads = rd; disp_writes = wr; disp_side_fx = fx;
        done_valid = dv; done_slot = IW'(ds);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst = 1'b1;
        disp_valid = 0; disp_reads = 0; disp_writes = 0; disp_side_fx = 0;
        done_valid = 0; done_slot = '0;
        cfg_lq_cap = '0; cfg_sq_cap = '0; cfg_strict_alias = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        want_vec(0, 0, "R1 empty after reset");
        want(F_ACC, 0, "R1 no accept without request");

        // ordering of plain loads and stores
        cyc(1, 1, 0, 0, 0, 0); want_acc(1, 0, "R2 load to slot 0"); want_vec(0, 0, "R1 still empty");
        cyc(1, 0, 1, 0, 0, 0); want_acc(1, 1, "R2 store to slot 1"); want_vec(8'h01, 0, "R11 lone load");
        cyc(1, 1, 0, 0, 0, 0); want_acc(1, 2, "R2 load to slot 2"); want_vec(8'h01, 0, "R3 store behind load");
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h01, 0, "R4 load behind store behind load");
        cyc(0, 0, 0, 0, 1, 0); want_vec(8'h01, 0, "R10 completion not yet visible");
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h06, 1, "R5 load passes store, R10 freed");
        cyc(0, 0, 0, 0, 0, 0); cfg_strict_alias = 1'b1;
        want_vec(8'h02, 1, "R5 strict mode holds load");
        cyc(1, 0, 1, 0, 1, 1); cfg_strict_alias = 1'b0;
        want_acc(1, 3, "R12 alloc with completion"); want_vec(8'h06, 1, "R12 before edge");
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h04, 2, "R12 both took effect, R3");
        cyc(0, 0, 0, 0, 1, 2); want_vec(8'h04, 2, "R3 store still held");
        cyc(0, 0, 0, 0, 1, 3); want_vec(8'h08, 3, "R3 store released");

        // load barrier
        cyc(1, 1, 0, 0, 0, 0); want_acc(1, 4, "R2 load slot 4"); want_vec(0, 0, "R10 ring drained");
        cyc(1, 1, 0, 1, 0, 0); want_acc(1, 5, "R2 load barrier slot 5"); want_vec(8'h10, 4, "R11 load 4");
        cyc(1, 1, 0, 0, 0, 0); want_acc(1, 6, "R2 load slot 6"); want_vec(8'h10, 4, "R6 barrier waits");
        cyc(1, 0, 1, 0, 0, 0); want_acc(1, 7, "R2 store slot 7"); want_vec(8'h10, 4, "R7 load behind load barrier");
        cyc(0, 0, 0, 0, 1, 4); want_vec(8'h10, 4, "R7 state unchanged");
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h20, 5, "R6 barrier oldest");
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h00, 0, "R6 single cycle permission");
        cyc(0, 0, 0, 0, 1, 6); want_vec(8'h40, 6, "R7 load released after barrier");
        cyc(0, 0, 0, 0, 1, 7); want_vec(8'h80, 7, "R3 store released");
        cyc(0, 0, 0, 0, 0, 0); want_vec(0, 0, "R10 empty again");
        idle(8);

        // capacity limits and full ring
        cyc(1, 1, 0, 0, 0, 0); cfg_lq_cap = CW'(2); want_acc(1, 0, "R8 load under limit");
        cyc(1, 1, 0, 0, 0, 0); want_acc(1, 1, "R8 second load");
        cyc(1, 1, 0, 0, 0, 0); want_acc(0, 0, "R8 limit of 2 reached");
        cyc(1, 1, 0, 0, 0, 0); cfg_lq_cap = '0; want_acc(1, 2, "R8 zero selects default");
        cyc(1, 1, 0, 0, 0, 0); want_acc(1, 3, "R8 fourth load");
        cyc(1, 1, 0, 0, 0, 0); want_acc(0, 0, "R8 default limit reached");
        cyc(1, 0, 1, 1, 0, 0); want_acc(1, 4, "R2 store barrier slot 4"); want_vec(8'h0F, 0, "R4 loads pass loads");
        cyc(1, 0, 1, 1, 0, 0); want_acc(1, 5, "R2 store barrier slot 5");
        cyc(1, 0, 1, 1, 0, 0); want_acc(1, 6, "R2 store barrier slot 6");
        cyc(1, 0, 1, 1, 0, 0); want_acc(1, 7, "R2 store barrier slot 7");
        cyc(1, 0, 1, 0, 1, 1); want_acc(0, 0, "R9 ring full"); want_vec(8'h0F, 0, "R9 full ring state");
        cyc(0, 0, 0, 0, 1, 0); want_vec(8'h0D, 0, "R11 hole in middle");
        cyc(0, 0, 0, 0, 1, 4); want_vec(8'h0C, 2, "R11 oldest skips freed slots");
        cyc(0, 0, 0, 0, 1, 2); want_vec(8'h0C, 2, "R10 barrier completion ignored");
        cyc(0, 0, 0, 0, 1, 3); want_vec(8'h08, 3, "R4 last load");
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h10, 4, "R10 barrier kept its slot");
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h00, 0, "R6 barrier executing");
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h20, 5, "R6 next barrier");
        idle(1);
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h40, 6, "R6 third barrier");
        idle(1);
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h80, 7, "R6 fourth barrier");
        idle(1);
        cyc(0, 0, 0, 0, 0, 0); want_vec(0, 0, "R6 ring drained");
        idle(8);

        // store barrier
        cyc(1, 0, 1, 0, 0, 0); want_acc(1, 0, "R2 store slot 0");
        cyc(1, 0, 1, 1, 0, 0); want_acc(1, 1, "R2 store barrier slot 1"); want_vec(8'h01, 0, "R3 lone store");
        cyc(1, 1, 0, 0, 0, 0); want_acc(1, 2, "R2 load slot 2"); want_vec(8'h01, 0, "R6 barrier behind store");
        cyc(1, 0, 1, 0, 0, 0); want_acc(1, 3, "R2 store slot 3"); want_vec(8'h05, 0, "R7 load passes store barrier");
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h05, 0, "R7 store held by store barrier");
        cyc(0, 0, 0, 0, 0, 0); cfg_strict_alias = 1'b1; want_vec(8'h01, 0, "R5 strict holds load");
        cyc(1, 1, 1, 1, 0, 0); cfg_strict_alias = 1'b0; want_acc(1, 4, "R2 full barrier accepted");
        cyc(1, 0, 0, 1, 0, 0); want_acc(0, 0, "R2 no read no write refused");
        cyc(0, 0, 0, 0, 0, 0); want_vec(8'h05, 0, "R6 full barrier waits");
        idle(2);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule